// File: doc/BRIEF.md
# Return-From-Trap Control Unit

This unit resolves what happens when a return-from-trap instruction retires. The pipeline gives it a single-cycle valid pulse with the current program counter, the debug bit taken from the instruction, and the live status bits: supervisor, previous supervisor and enable-traps. With the same pulse it receives the saved return addresses and a flag that says whether the core is in debug mode. One saved address is for normal trap returns. The other is for debug returns and comes with its own saved enable and supervisor bits.

One cycle later the unit presents a registered result. This holds the next program counter and, when a return is taken, a one-cycle status write strobe with the new supervisor and enable-traps values. It may also assert a request to leave debug mode, an illegal-instruction request and a halt request. The conditions are tested in a fixed order. If a return is attempted from the wrong privilege level, the wrong trap state or the wrong mode, the core carries on at the following instruction and no return takes place.

Top module: `rft_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, `done`, `st_we`, `dbg_clr`, `illegal` and `halt` are 0 and `next_pc` is 0.
- R2: A cycle with `ret_vld` low produces all strobes (`done`, `st_we`, `dbg_clr`, `illegal`, `halt`) at 0 on the next cycle, and `next_pc` keeps its previous value.
- R3: If `cur_s` is 0, the result is `next_pc = cur_pc + 4`, with no status write, no illegal request and no debug clear. `halt` is 1 exactly when `cur_et` is 0. This check has the highest priority.
- R4: If `cur_s` is 1 and `cur_et` is 1, both `illegal` and `halt` are 1 and `next_pc = cur_pc + 4`, with no status write.
- R5: If `cur_s` is 1, `cur_et` is 0, `in_dbg` is 0 and `dbg_bit` is 0, then `next_pc` is `saved_pc` and `st_we` pulses. In the status write `new_et` is 1 and `new_s` equals `cur_ps`.
- R6: If `cur_s` is 1, `cur_et` is 0, `in_dbg` is 1 and `dbg_bit` is 1, then `next_pc` is `saved_dbg_pc` and `st_we` and `dbg_clr` pulse. In the status write `new_et` equals `saved_dbg_et` and `new_s` equals `saved_dbg_s`.
- R7: If `cur_s` is 1 and `cur_et` is 0 but `in_dbg` and `dbg_bit` differ, then `next_pc = cur_pc + 4` and every other strobe stays 0.
- R8: `done` and every other strobe appear exactly one cycle after the `ret_vld` cycle and last a single cycle.
- R9: The increment wraps modulo 2^32, so `cur_pc = 0xFFFFFFFC` gives `next_pc = 0`.
- R10: The saved return addresses are treated as word aligned. Bits [1:0] of `next_pc` are 0 on both return paths, whatever those bits are in `saved_pc` or `saved_dbg_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_vld | input | 1 | Return-from-trap retires this cycle |
| cur_pc | input | 32 | Address of the return instruction |
| dbg_bit | input | 1 | Debug bit from the instruction |
| cur_s | input | 1 | Current supervisor bit |
| cur_ps | input | 1 | Previous supervisor bit |
| cur_et | input | 1 | Current enable-traps bit |
| in_dbg | input | 1 | Core is in debug mode |
| saved_pc | input | 32 | Saved normal-mode return address |
| saved_dbg_pc | input | 32 | Saved debug-mode return address |
| saved_dbg_et | input | 1 | Saved debug enable-traps bit |
| saved_dbg_s | input | 1 | Saved debug supervisor bit |
| done | output | 1 | Result valid strobe |
| next_pc | output | 32 | Next program counter |
| st_we | output | 1 | Status write strobe |
| new_s | output | 1 | Supervisor value to write |
| new_et | output | 1 | Enable-traps value to write |
| dbg_clr | output | 1 | Leave debug mode |
| illegal | output | 1 | Illegal-instruction request |
| halt | output | 1 | Halt request |

## Verification
The bench tries every combination of the five control inputs (supervisor, previous supervisor, enable-traps, debug mode and the instruction's debug bit). This shows that the priority order picks exactly one of the five outcomes for every one of the 32 cases. Each combination runs under all four values of the saved debug bits, so a mixed-up source for the new status bits shows up. Three program counters are used: an ordinary one, one at the top of the address space that tests the wrap, and saved addresses with their low bits set that test the alignment mask. After each pulse comes an idle cycle, which shows that the strobes drop and the address holds.

// File: rtl/rft_pkg.sv
package rft_pkg;
  typedef enum logic [2:0] {
    PATH_USER   = 3'd0,
    PATH_TRAPON = 3'd1,
    PATH_NORM   = 3'd2,
    PATH_DBG    = 3'd3,
    PATH_SKIP   = 3'd4
  } rft_path_e;
endpackage

// File: rtl/rft_decide.sv
module rft_decide
  import rft_pkg::*;
(
  input  logic      sup,
  input  logic      et,
  input  logic      dmode,
  input  logic      dbit,
  output rft_path_e path
);
  // fixed priority: privilege, then trap state, then normal, then debug
  always_comb begin
    if (!sup)                path = PATH_USER;
    else if (et)             path = PATH_TRAPON;
    else if (!dmode && !dbit) path = PATH_NORM;
    else if (dmode && dbit)  path = PATH_DBG;
    else                     path = PATH_SKIP;
  end
endmodule

// File: rtl/rft_pcsel.sv
module rft_pcsel
  import rft_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int STEP_BYTES = 4
) (
  input  rft_path_e         path,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] ret_norm,
  input  logic [ADDR_W-1:0] ret_dbg,
  output logic [ADDR_W-1:0] pc_out
);
  localparam int ALIGN_W = $clog2(STEP_BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_BYTES);
  localparam logic [ADDR_W-1:0] MASK = {{(ADDR_W-ALIGN_W){1'b1}}, {ALIGN_W{1'b0}}};

  logic [ADDR_W-1:0] seq_pc;
  assign seq_pc = pc + STEP;  // wraps modulo 2^ADDR_W

  always_comb begin
    unique case (path)
      PATH_NORM: pc_out = ret_norm & MASK;
      PATH_DBG:  pc_out = ret_dbg & MASK;
      default:   pc_out = seq_pc;
    endcase
  end
endmodule

// File: rtl/rft_unit.sv
module rft_unit
  import rft_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int STEP_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ret_vld,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              dbg_bit,
  input  logic              cur_s,
  input  logic              cur_ps,
  input  logic              cur_et,
  input  logic              in_dbg,
  input  logic [ADDR_W-1:0] saved_pc,
  input  logic [ADDR_W-1:0] saved_dbg_pc,
  input  logic              saved_dbg_et,
  input  logic              saved_dbg_s,
  output logic              done,
  output logic [ADDR_W-1:0] next_pc,
  output logic              st_we,
  output logic              new_s,
  output logic              new_et,
  output logic              dbg_clr,
  output logic              illegal,
  output logic              halt
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_BYTES);

  rft_path_e         path;
  logic [ADDR_W-1:0] pc_sel;

  rft_decide u_decide (
    .sup   (cur_s),
    .et    (cur_et),
    .dmode (in_dbg),
    .dbit  (dbg_bit),
    .path  (path)
  );

  rft_pcsel #(.ADDR_W(ADDR_W), .STEP_BYTES(STEP_BYTES)) u_pcsel (
    .path     (path),
    .pc       (cur_pc),
    .ret_norm (saved_pc),
    .ret_dbg  (saved_dbg_pc),
    .pc_out   (pc_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      next_pc <= '0;
      st_we   <= 1'b0;
      new_s   <= 1'b0;
      new_et  <= 1'b0;
      dbg_clr <= 1'b0;
      illegal <= 1'b0;
      halt    <= 1'b0;
    end else begin
      done    <= ret_vld;
      st_we   <= ret_vld && (path == PATH_NORM || path == PATH_DBG);
      dbg_clr <= ret_vld && (path == PATH_DBG);
      illegal <= ret_vld && (path == PATH_TRAPON);
      halt    <= ret_vld && ((path == PATH_TRAPON) || (path == PATH_USER && !cur_et));
      if (ret_vld) begin
        next_pc <= pc_sel;
        new_s   <= (path == PATH_DBG) ? saved_dbg_s : cur_ps;
        new_et  <= (path == PATH_DBG) ? saved_dbg_et : 1'b1;
      end
    end
  end

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !ret_vld |=> (!done && !st_we && !dbg_clr && !illegal && !halt));
  // R3
  user_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_vld && !cur_s) |=> (!st_we && !illegal && !dbg_clr));
  // R4
  trapon_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_vld && cur_s && cur_et) |=> (illegal && halt && !st_we));
  // R6
  dbg_clr_with_write_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_clr |-> (st_we && done));
  // R8
  strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_vld && !$past(ret_vld)) |=> (done && $past(!done)));
  // R9
  seq_pc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !st_we) |-> (next_pc == $past(cur_pc) + STEP));
  // R10
  ret_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    st_we |-> (next_pc[1:0] == 2'b00));
endmodule

// File: tb/rft_unit_tb_top.sv
module rft_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ret_vld = 1'b0;
  logic [31:0] cur_pc = '0;
  logic        dbg_bit = 1'b0, cur_s = 1'b0, cur_ps = 1'b0, cur_et = 1'b0, in_dbg = 1'b0;
  logic [31:0] saved_pc = '0, saved_dbg_pc = '0;
  logic        saved_dbg_et = 1'b0, saved_dbg_s = 1'b0;
  logic        done, st_we, new_s, new_et, dbg_clr, illegal, halt;
  logic [31:0] next_pc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  rft_unit dut_i (
    .clk(clk), .rst(rst), .ret_vld(ret_vld), .cur_pc(cur_pc), .dbg_bit(dbg_bit),
    .cur_s(cur_s), .cur_ps(cur_ps), .cur_et(cur_et), .in_dbg(in_dbg),
    .saved_pc(saved_pc), .saved_dbg_pc(saved_dbg_pc),
    .saved_dbg_et(saved_dbg_et), .saved_dbg_s(saved_dbg_s),
    .done(done), .next_pc(next_pc), .st_we(st_we), .new_s(new_s), .new_et(new_et),
    .dbg_clr(dbg_clr), .illegal(illegal), .halt(halt)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] pack(input logic d, input logic w, input logic s, input logic e,
                                      input logic c, input logic i, input logic h);
    return {d, w, s, e, c, i, h};
  endfunction

  initial begin
    logic [31:0] pcs [3];
    pcs[0] = 32'h0000_1000;
    pcs[1] = 32'hFFFF_FFFC;
    pcs[2] = 32'h4000_0020;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs while reset is held
    chk(pack(done, st_we, 1'b0, 1'b0, dbg_clr, illegal, halt) == 7'd0 && next_pc == 0,
        "R1", {25'd0, pack(done, st_we, 1'b0, 1'b0, dbg_clr, illegal, halt)}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !halt && next_pc == 0, "R1", next_pc, 32'd0);

    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 128; k++) begin
        logic s, ps, e, db, dm, bs, be;
        logic [31:0] epc, spc, sdpc;
        logic ew, ens, enet, eclr, eill, ehalt;
        string req;
        {s, ps, e, db, dm, bs, be} = 7'(k);
        spc  = pcs[p] + 32'h0000_0100 + 32'(k % 4);
        sdpc = pcs[p] ^ 32'h0800_0000 | 32'(3 - (k % 4));
        ew = 0; ens = 0; enet = 0; eclr = 0; eill = 0; ehalt = 0;
        epc = pcs[p] + 32'd4;
        if (!s) begin req = "R3"; ehalt = !e; end
        else if (e) begin req = "R4"; eill = 1; ehalt = 1; end
        else if (!dm && !db) begin req = "R5"; epc = spc & ~32'd3; ew = 1; ens = ps; enet = 1; end
        else if (dm && db) begin req = "R6"; epc = sdpc & ~32'd3; ew = 1; ens = bs; enet = be; eclr = 1; end
        else req = "R7";
        if (p == 1 && !ew) req = "R9";
        if (p == 2 && ew) req = "R10";
        // drive one-cycle pulse
        cur_pc = pcs[p]; cur_s = s; cur_ps = ps; cur_et = e; dbg_bit = db; in_dbg = dm;
        saved_pc = spc; saved_dbg_pc = sdpc; saved_dbg_s = bs; saved_dbg_et = be;
        ret_vld = 1'b1;
        @(negedge clk);
        ret_vld = 1'b0;
        // R8: result present one cycle after the pulse
        chk(done, "R8", {31'd0, done}, 32'd1);
        chk(next_pc == epc, req, next_pc, epc);
        chk({st_we, dbg_clr, illegal, halt} == {ew, eclr, eill, ehalt}, req,
            {28'd0, st_we, dbg_clr, illegal, halt}, {28'd0, ew, eclr, eill, ehalt});
        if (ew)
          chk({new_s, new_et} == {ens, enet}, req, {30'd0, new_s, new_et}, {30'd0, ens, enet});
        @(negedge clk);
        // R2: idle cycle drops strobes and holds the address
        chk({done, st_we, dbg_clr, illegal, halt} == 5'd0 && next_pc == epc, "R2",
            {27'd0, done, st_we, dbg_clr, illegal, halt}, 32'd0);
      end
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule